// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This block performs the 32 x 32 -> 64-bit long multiply of a 32-bit RISC core. It takes one instruction word together with the three register values the core has already read: the multiplicand, the multiplier and the accumulate value. From the instruction it extracts a high-destination index, a low-destination index, a multiplier index and a multiplicand index. An instruction bit selects signed or unsigned arithmetic. A second bit adds the 32-bit accumulate value, extended to 64 bits according to the mode.

The product is formed by a radix-2 shift-add engine that takes 32 cycles. When it finishes, the unit raises `done` for one cycle. In that cycle it asserts two write enables, with the upper word of the result routed to the high destination index and the lower word to the low destination index. An instruction whose register fields break the legality rules is not executed. Instead it completes on the next cycle, with an undefined-instruction flag and no write enables. The register file, the condition evaluation and the flag updates are handled elsewhere in the core.

Top module: `lmac_unit`

## Requirements
- R1: Field positions in `instr`: high destination index is bits 19:16, low destination index bits 15:12, multiplier index bits 11:8, multiplicand index bits 3:0. On a completing `done`, `hi_idx` and `lo_idx` carry the fields of the accepted instruction.
- R2: When `instr[22]` is 0, both `rm_val` and `rs_val` are zero-extended and the 64-bit product is their unsigned product.
- R3: When `instr[22]` is 1, both operands are two's-complement and the 64-bit result is their signed product.
- R4: When `instr[21]` is 1, `acc_val` is added to the product. It is sign-extended in signed mode and zero-extended in unsigned mode. When `instr[21]` is 0, `acc_val` has no effect. The sum wraps modulo 2^64.
- R5: `hi_data` carries result bits 63:32 and `lo_data` carries result bits 31:0.
- R6: The instruction is undefined if any of the four register fields equals 15.
- R7: The instruction is undefined if the high index equals the multiplicand index, if the low index equals the multiplicand index, or if the high index equals the low index. The multiplier index may equal the multiplicand index.
- R8: An undefined instruction raises `done` and `undef_exc` in the cycle after it is accepted, with `hi_we` and `lo_we` both low.
- R9: A legal instruction raises `done`, `hi_we` and `lo_we` exactly 32 cycles after the clock edge that accepted it. `done` lasts one cycle.
- R10: `start` is accepted only when `busy` and `done` are both low. A `start` at any other time has no effect on the pending result or on the indices.
- R11: A synchronous active-high `rst` clears `busy`, `done`, `undef_exc` and both write enables. An operation in flight is abandoned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to execute `instr` |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Multiplicand register value |
| rs_val | input | 32 | Multiplier register value |
| acc_val | input | 32 | Value of the low-destination register, used as the accumulate term |
| busy | output | 1 | Shift-add engine is running |
| done | output | 1 | One-cycle completion pulse |
| undef_exc | output | 1 | Undefined-instruction exception, valid with `done` |
| hi_we | output | 1 | Write enable for the high destination |
| hi_idx | output | 4 | High destination register index |
| hi_data | output | 32 | Result bits 63:32 |
| lo_we | output | 1 | Write enable for the low destination |
| lo_idx | output | 4 | Low destination register index |
| lo_data | output | 32 | Result bits 31:0 |

## Verification
The bench targets the signed step with multiplier bit 31 set. A design that adds that weight instead of subtracting it returns a result that is off by 2^32 times the multiplicand. It also exercises the accumulate term with its top bit set, where wrong extension shows up as a wrong high word: 0xFFFFFFFF must count as -1 in signed mode and as 2^32-1 in unsigned mode. Each legality rule is driven on its own, along with the one aliasing that is permitted (multiplier equal to multiplicand). This catches a swapped index comparison that either traps a legal instruction or writes an illegal one. A `start` pulse arrives in the middle of a run and again during `done`, and a reset arrives mid-run. This exposes a unit that reloads its operands or indices, or one that lets a stale completion out.

// File: rtl/lmac_pkg.sv
`timescale 1ns/1ps
package lmac_pkg;
  parameter int unsigned DW = 32;   // data width
  parameter int unsigned IW = 32;   // instruction width
  parameter int unsigned RW = 4;    // register index width

  localparam int unsigned HI_POS  = 16;
  localparam int unsigned LO_POS  = 12;
  localparam int unsigned RS_POS  = 8;
  localparam int unsigned RM_POS  = 0;
  localparam int unsigned SGN_BIT = 22;
  localparam int unsigned ACC_BIT = 21;
  localparam logic [RW-1:0] BAD_IDX = '1;

  typedef struct packed {
    logic [RW-1:0] hi;
    logic [RW-1:0] lo;
    logic [RW-1:0] rs;
    logic [RW-1:0] rm;
    logic          sgn;
    logic          acc_en;
  } lmac_fields_t;

  function automatic lmac_fields_t fields_f(input logic [IW-1:0] ins);
    lmac_fields_t f;
    f.hi     = ins[HI_POS +: RW];
    f.lo     = ins[LO_POS +: RW];
    f.rs     = ins[RS_POS +: RW];
    f.rm     = ins[RM_POS +: RW];
    f.sgn    = ins[SGN_BIT];
    f.acc_en = ins[ACC_BIT];
    return f;
  endfunction

  function automatic logic illegal_f(input lmac_fields_t f);
    logic pc_use, alias_use;
    pc_use    = (f.hi == BAD_IDX) || (f.lo == BAD_IDX) ||
                (f.rs == BAD_IDX) || (f.rm == BAD_IDX);
    alias_use = (f.hi == f.rm) || (f.lo == f.rm) || (f.hi == f.lo);
    return pc_use || alias_use;
  endfunction

  function automatic logic [2*DW-1:0] ext_f(input logic [DW-1:0] v, input logic sgn);
    return sgn ? {{DW{v[DW-1]}}, v} : {{DW{1'b0}}, v};
  endfunction

  // one radix-2 step: add (or, for the signed top bit, subtract) the shifted multiplicand
  function automatic logic [2*DW-1:0] step_f(input logic [2*DW-1:0] acc,
                                             input logic [2*DW-1:0] mcand,
                                             input logic            mbit,
                                             input logic            neg);
    if (!mbit)
      return acc;
    return neg ? (acc - mcand) : (acc + mcand);
  endfunction
endpackage

// File: rtl/lmac_decode.sv
`timescale 1ns/1ps
module lmac_decode
  import lmac_pkg::*;
(
  input  logic [IW-1:0] instr,
  output lmac_fields_t  fields,
  output logic          illegal
);
  logic unused_bits;
  assign unused_bits = ^{instr[IW-1:SGN_BIT+1], instr[ACC_BIT-1:HI_POS+RW],
                         instr[RS_POS-1:RM_POS+RW]};
  assign fields  = fields_f(instr);
  assign illegal = illegal_f(fields);
endmodule

// File: rtl/lmac_shiftadd.sv
`timescale 1ns/1ps
module lmac_shiftadd
  import lmac_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           sgn,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  input  logic [2*W-1:0] init,
  output logic           busy,
  output logic           last,
  output logic [2*W-1:0] product
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW-1:0] LAST_CNT = CW'(W-1);

  logic [2*W-1:0] acc_q, mcand_q;
  logic [W-1:0]   mplier_q;
  logic [CW-1:0]  cnt_q;
  logic           busy_q, sgn_q;

  assign last    = busy_q && (cnt_q == LAST_CNT);
  assign busy    = busy_q;
  assign product = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      sgn_q    <= 1'b0;
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
    end else if (load && !busy_q) begin
      busy_q   <= 1'b1;
      cnt_q    <= '0;
      sgn_q    <= sgn;
      acc_q    <= init;
      mcand_q  <= ext_f(mcand_in, sgn);
      mplier_q <= mplier_in;
    end else if (busy_q) begin
      acc_q    <= step_f(acc_q, mcand_q, mplier_q[0], sgn_q && (cnt_q == LAST_CNT));
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      cnt_q    <= cnt_q + 1'b1;
      if (cnt_q == LAST_CNT)
        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lmac_unit.sv
`timescale 1ns/1ps
module lmac_unit
  import lmac_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [31:0]   instr,
  input  logic [31:0]   rm_val,
  input  logic [31:0]   rs_val,
  input  logic [31:0]   acc_val,
  output logic          busy,
  output logic          done,
  output logic          undef_exc,
  output logic          hi_we,
  output logic [3:0]    hi_idx,
  output logic [31:0]   hi_data,
  output logic          lo_we,
  output logic [3:0]    lo_idx,
  output logic [31:0]   lo_data
);
  lmac_fields_t    fields;
  logic            illegal;
  logic            accept;
  logic            eng_busy, eng_last;
  logic [2*DW-1:0] eng_init, eng_prod;
  logic            done_q, undef_q;
  logic [RW-1:0]   hi_idx_q, lo_idx_q;

  lmac_decode u_dec (
    .instr   (instr),
    .fields  (fields),
    .illegal (illegal)
  );

  assign accept   = start && !eng_busy && !done_q;
  assign eng_init = fields.acc_en ? ext_f(acc_val, fields.sgn) : '0;

  lmac_shiftadd #(.W(DW)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .load      (accept && !illegal),
    .sgn       (fields.sgn),
    .mcand_in  (rm_val),
    .mplier_in (rs_val),
    .init      (eng_init),
    .busy      (eng_busy),
    .last      (eng_last),
    .product   (eng_prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      undef_q  <= 1'b0;
      hi_idx_q <= '0;
      lo_idx_q <= '0;
    end else begin
      done_q  <= 1'b0;
      undef_q <= 1'b0;
      if (accept) begin
        hi_idx_q <= fields.hi;
        lo_idx_q <= fields.lo;
        if (illegal) begin
          done_q  <= 1'b1;
          undef_q <= 1'b1;
        end
      end else if (eng_last) begin
        done_q <= 1'b1;
      end
    end
  end

  assign busy      = eng_busy;
  assign done      = done_q;
  assign undef_exc = undef_q;
  assign hi_we     = done_q && !undef_q;
  assign lo_we     = done_q && !undef_q;
  assign hi_idx    = hi_idx_q;
  assign lo_idx    = lo_idx_q;
  assign hi_data   = eng_prod[2*DW-1:DW];
  assign lo_data   = eng_prod[DW-1:0];
endmodule

// File: rtl/lmac_checker.sv
`timescale 1ns/1ps
module lmac_checker
  import lmac_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic          illegal,
  input logic [RW-1:0] f_hi,
  input logic [RW-1:0] f_lo,
  input logic [RW-1:0] f_rs,
  input logic [RW-1:0] f_rm,
  input logic          busy,
  input logic          done,
  input logic          undef_exc,
  input logic          hi_we,
  input logic          lo_we,
  input logic [RW-1:0] hi_idx,
  input logic [RW-1:0] lo_idx
);
  localparam int unsigned CCW = $clog2(DW) + 2;
  localparam logic [CCW-1:0] CC_MAX = '1;
  localparam logic [CCW-1:0] LAT    = CCW'(DW);

  logic [CCW-1:0] cc;
  always_ff @(posedge clk) begin
    if (rst || accept) cc <= '0;
    else if (cc != CC_MAX) cc <= cc + 1'b1;
  end

  assert_reg15_R6: assert property (@(posedge clk) disable iff (rst)
    accept && (f_hi == BAD_IDX || f_lo == BAD_IDX || f_rs == BAD_IDX || f_rm == BAD_IDX) |-> illegal);
  assert_alias_R7: assert property (@(posedge clk) disable iff (rst)
    accept && (f_hi == f_rm || f_lo == f_rm || f_hi == f_lo) |-> illegal);
  assert_undef_next_R8: assert property (@(posedge clk) disable iff (rst)
    accept && illegal |=> done && undef_exc && !busy);
  assert_undef_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    undef_exc |-> !hi_we && !lo_we);
  assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
    done && !undef_exc |-> (cc == LAT) && hi_we && lo_we);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_idx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hi_idx) && $stable(lo_idx));
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> !busy && !done && !undef_exc && !hi_we && !lo_we);
endmodule

bind lmac_unit lmac_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .accept    (accept),
  .illegal   (illegal),
  .f_hi      (instr[19:16]),
  .f_lo      (instr[15:12]),
  .f_rs      (instr[11:8]),
  .f_rm      (instr[3:0]),
  .busy      (busy),
  .done      (done),
  .undef_exc (undef_exc),
  .hi_we     (hi_we),
  .lo_we     (lo_we),
  .hi_idx    (hi_idx),
  .lo_idx    (lo_idx)
);

// File: tb/sim_lmac_unit.sv
`timescale 1ns/1ps
module sim_lmac_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] instr = '0, rm_val = '0, rs_val = '0, acc_val = '0;
  logic busy, done, undef_exc, hi_we, lo_we;
  logic [3:0] hi_idx, lo_idx;
  logic [31:0] hi_data, lo_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lmac_unit u0 (
    .clk(clk), .rst(rst), .start(start), .instr(instr),
    .rm_val(rm_val), .rs_val(rs_val), .acc_val(acc_val),
    .busy(busy), .done(done), .undef_exc(undef_exc),
    .hi_we(hi_we), .hi_idx(hi_idx), .hi_data(hi_data),
    .lo_we(lo_we), .lo_idx(lo_idx), .lo_data(lo_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // instruction layout: [22] signed, [21] accumulate, [19:16] hi, [15:12] lo, [11:8] rs, [3:0] rm
  function automatic logic [31:0] mk(input logic [3:0] h, input logic [3:0] l,
                                     input logic [3:0] s, input logic [3:0] m,
                                     input logic sg, input logic ac);
    return {9'b0, sg, ac, 1'b0, h, l, s, 4'b1001, m};
  endfunction

  function automatic logic [63:0] model(input logic sg, input logic ac,
                                        input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] c);
    logic [63:0] xa, xb, xc;
    xa = sg ? {{32{a[31]}}, a} : {32'h0, a};
    xb = sg ? {{32{b[31]}}, b} : {32'h0, b};
    xc = !ac ? 64'h0 : (sg ? {{32{c[31]}}, c} : {32'h0, c});
    return xa * xb + xc;
  endfunction

  function automatic bit is_bad(input logic [31:0] ins);
    logic [3:0] h, l, s, m;
    h = ins[19:16]; l = ins[15:12]; s = ins[11:8]; m = ins[3:0];
    return (h == 4'hF) || (l == 4'hF) || (s == 4'hF) || (m == 4'hF) ||
           (h == m) || (l == m) || (h == l);
  endfunction

  // issue one op and check it; req names the requirement under test
  task automatic run_op(input string req, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    int k;
    bit bad;
    logic [63:0] exp;
    bad = is_bad(ins);
    exp = model(ins[22], ins[21], a, b, c);
    @(negedge clk);
    instr = ins; rm_val = a; rs_val = b; acc_val = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rm_val = 32'hDEAD_BEEF; rs_val = 32'h1357_9BDF; acc_val = 32'hA5A5_5A5A;
    k = 0;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    if (bad) begin
      chk(k == 0, req, "undef completion latency (R8)", 64'(k), 64'd0);
      chk(undef_exc == 1'b1, req, "undef flag (R8)", 64'(undef_exc), 64'd1);
      chk(!hi_we && !lo_we, req, "write enables on undef (R8)", 64'({hi_we, lo_we}), 64'd0);
    end else begin
      chk(k == 32, req, "legal completion latency (R9)", 64'(k), 64'd32);
      chk(!undef_exc && hi_we && lo_we, req, "flags on legal done (R9)",
          64'({undef_exc, hi_we, lo_we}), 64'b011);
      chk({hi_data, lo_data} == exp, req, "result hi:lo (R5)", {hi_data, lo_data}, exp);
      chk(hi_idx == ins[19:16] && lo_idx == ins[15:12], req, "dest indices (R1)",
          64'({hi_idx, lo_idx}), 64'({ins[19:16], ins[15:12]}));
    end
    @(negedge clk);
    chk(!done, req, "done is one cycle (R9)", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk(!busy && !done && !undef_exc && !hi_we && !lo_we, "R11", "state after reset",
        64'({busy, done, undef_exc, hi_we, lo_we}), 64'd0);
  endtask

  task automatic t_unsigned;
    run_op("R2", mk(4'd1, 4'd2, 4'd3, 4'd4, 1'b0, 1'b0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    run_op("R2", mk(4'd9, 4'd0, 4'd5, 4'd7, 1'b0, 1'b0), 32'h1234_5678, 32'h9ABC_DEF0, 32'h0);
    run_op("R2", mk(4'd14, 4'd13, 4'd12, 4'd11, 1'b0, 1'b0), 32'h0, 32'h8000_0001, 32'h0);
    run_op("R5", mk(4'd3, 4'd8, 4'd1, 4'd6, 1'b0, 1'b0), 32'h8000_0000, 32'h0000_0002, 32'h0);
  endtask

  task automatic t_signed;
    run_op("R3", mk(4'd1, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0);
    run_op("R3", mk(4'd1, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0), 32'h8000_0000, 32'h8000_0000, 32'h0);
    run_op("R3", mk(4'd1, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0), 32'h7FFF_FFFF, 32'h8000_0000, 32'h0);
    run_op("R3", mk(4'd1, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0), 32'h0000_0003, 32'hFFFF_FFF9, 32'h0);
  endtask

  task automatic t_accumulate;
    run_op("R4", mk(4'd5, 4'd6, 4'd7, 4'd8, 1'b0, 1'b1), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R4", mk(4'd5, 4'd6, 4'd7, 4'd8, 1'b1, 1'b1), 32'h0000_0000, 32'h1234_0000, 32'hFFFF_FFFF);
    run_op("R4", mk(4'd5, 4'd6, 4'd7, 4'd8, 1'b1, 1'b1), 32'hFFFF_FFFE, 32'h0000_0005, 32'h7FFF_FFFF);
    run_op("R4", mk(4'd5, 4'd6, 4'd7, 4'd8, 1'b0, 1'b0), 32'h0000_0010, 32'h0000_0010, 32'hFFFF_FFFF);
  endtask

  task automatic t_reg15;
    run_op("R6", mk(4'd15, 4'd2, 4'd3, 4'd4, 1'b0, 1'b0), 32'h5, 32'h6, 32'h0);
    run_op("R6", mk(4'd1, 4'd15, 4'd3, 4'd4, 1'b0, 1'b1), 32'h5, 32'h6, 32'h0);
    run_op("R6", mk(4'd1, 4'd2, 4'd15, 4'd4, 1'b1, 1'b0), 32'h5, 32'h6, 32'h0);
    run_op("R6", mk(4'd1, 4'd2, 4'd3, 4'd15, 1'b1, 1'b1), 32'h5, 32'h6, 32'h0);
  endtask

  task automatic t_alias;
    run_op("R7", mk(4'd4, 4'd2, 4'd3, 4'd4, 1'b0, 1'b0), 32'h5, 32'h6, 32'h0);
    run_op("R7", mk(4'd1, 4'd4, 4'd3, 4'd4, 1'b0, 1'b0), 32'h5, 32'h6, 32'h0);
    run_op("R7", mk(4'd2, 4'd2, 4'd3, 4'd4, 1'b1, 1'b1), 32'h5, 32'h6, 32'h0);
    // multiplier equal to multiplicand is legal
    run_op("R7", mk(4'd1, 4'd2, 4'd4, 4'd4, 1'b0, 1'b0), 32'h0001_0000, 32'h0001_0000, 32'h0);
  endtask

  task automatic t_busy_ignore;
    int k;
    logic [63:0] exp;
    exp = model(1'b0, 1'b1, 32'h0000_1000, 32'h0000_2000, 32'h0000_0007);
    @(negedge clk);
    instr = mk(4'd1, 4'd2, 4'd3, 4'd4, 1'b0, 1'b1);
    rm_val = 32'h0000_1000; rs_val = 32'h0000_2000; acc_val = 32'h0000_0007; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    instr = mk(4'd9, 4'd10, 4'd11, 4'd12, 1'b1, 1'b0);
    rm_val = 32'hFFFF_0000; rs_val = 32'h0F0F_0F0F; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 6;
    while (!done && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(k == 32, "R10", "latency with start while busy", 64'(k), 64'd32);
    chk({hi_data, lo_data} == exp, "R10", "result unaffected by start while busy",
        {hi_data, lo_data}, exp);
    chk(hi_idx == 4'd1 && lo_idx == 4'd2, "R10", "indices unaffected by start while busy",
        64'({hi_idx, lo_idx}), 64'h12);
    // start during the done cycle must be ignored as well
    instr = mk(4'd5, 4'd6, 4'd7, 4'd8, 1'b0, 1'b0); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R10", "start during done not accepted",
        64'({busy, done}), 64'd0);
  endtask

  task automatic t_reset_mid;
    bit seen;
    @(negedge clk);
    instr = mk(4'd1, 4'd2, 4'd3, 4'd4, 1'b0, 1'b0);
    rm_val = 32'h3; rs_val = 32'h4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy, "R11", "busy before mid-run reset", 64'(busy), 64'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done, "R11", "reset clears busy mid-run", 64'({busy, done}), 64'd0);
    seen = 1'b0;
    repeat (40) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(!seen, "R11", "no completion after reset", 64'(seen), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_unsigned();
    t_signed();
    t_accumulate();
    t_reg15();
    t_alias();
    t_busy_ignore();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc >= 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule